// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a bank of identical timer channels placed behind a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each channel holds three things: a control word, an interval value and a live count.

A started channel loads its interval and then counts down. Each decrement comes from one of two tick strobes. Ticks on the fast strobe are used directly. Ticks on the slow strobe pass through a power-of-two divider first. When a tick arrives while the count is zero, the channel expires. Expiry raises the channel's status bit. In periodic mode the interval is reloaded and counting continues. In one-shot mode the channel switches itself off.

A per-channel enable mask and a write-one-to-clear status word together drive one interrupt line. Software reprograms a running channel in three steps: switch it off, write the new interval, then write enable and reload together. A stopped channel refuses to restart until two ticks of its selected source have passed. A restart written earlier than that is held back and carried out as soon as the wait is over.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register map: interrupt mask at 0x00, status at 0x04; channel n has control at 0x10*n+0x10, interval at 0x10*n+0x14, read-only count at 0x10*n+0x18. Control bits: [0] enable, [1] reload, [3:2] source, [6:4] divider code, [7] one-shot, [31] guard busy (read-only). Writing a control word with bit 0 and bit 1 set copies the interval into the count on the next clock edge, when no guard is running. Bit 1 reads 1 only while that copy is still pending.
- R3: With source value 1, the count drops by exactly one per fast tick, and slow ticks have no effect on it.
- R4: With bit 7 clear, a tick that finds the count at zero sets status bit n and reloads the interval. The period is therefore interval+1 ticks.
- R5: With bit 7 set, the expiring tick sets status bit n and clears control bit 0. The count stays at zero on all later ticks.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: `irq_o` is the OR over all channels of (status bit n AND mask bit n).
- R8: A write to the interval register is ignored while control bit 0 is set, and accepted while it is clear.
- R9: When control bit 0 goes from 1 to 0 (by a write or by one-shot expiry), control bit 31 reads 1. It stays 1 until two raw ticks of the selected source have passed. An enable written during that time is held off: the count is frozen, and the load takes place only after the guard ends.
- R10: With any source value other than 1, the count drops once per 2^k slow ticks, where k is bits [6:4]. Fast ticks are ignored. The divider restarts from zero every time the channel starts.
- R11: When an expiry and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_hf_i | input | 1 | Fast source tick strobe, one cycle wide |
| tick_lf_i | input | 1 | Slow source tick strobe, one cycle wide |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt |

## Verification
A register write lands on the clock edge where the strobe is sampled. Status, mask and the interrupt line can be read back straight after that edge. A start is slower: the interval reaches the count one edge after the start write. For that reason every start is followed by one idle cycle before any tick is driven. Each tick strobe covers exactly one edge, so its decrement, expiry or guard step is visible at the next falling edge. Every check is taken at a falling edge once that many edges have passed, and the expected count is worked out in the bench from the period and divider rules.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   // control word layout; the positions are decoded by the channel logic
   typedef struct packed {
      logic       oneshot;  // [7]
      logic [2:0] div;      // [6:4]
      logic [1:0] src;      // [3:2]
      logic       reload;   // [1]
      logic       en;       // [0]
   } ctl_t;

   localparam int          CTL_W       = 8;
   localparam int          BUSY_BIT    = 31;
   localparam logic [1:0]  SRC_FAST    = 2'd1;
   localparam int          OFS_MASK    = 'h00;
   localparam int          OFS_STAT    = 'h04;
   localparam int          CH_BASE     = 'h10;
   localparam int          CH_STRIDE   = 'h10;
   localparam int          SUB_CTL     = 'h0;
   localparam int          SUB_IVAL    = 'h4;
   localparam int          SUB_CNT     = 'h8;
   localparam logic [1:0]  GUARD_TICKS = 2'd2;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);
   localparam int PCNT_W = (1 << CODE_W) - 1;

   logic [PCNT_W-1:0] pcnt_q;
   logic [PCNT_W-1:0] mask;

   assign mask   = ~({PCNT_W{1'b1}} << code_i);
   assign tick_o = tick_i && ((pcnt_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) pcnt_q <= '0;
      else if (tick_i)     pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tick_timer_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int CODE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_hf_i,
   input  logic             tick_lf_i,
   input  logic             ctl_we_i,
   input  ctl_t             ctl_wd_i,
   input  logic             ival_we_i,
   input  logic [CNT_W-1:0] ival_wd_i,
   output ctl_t             ctl_o,
   output logic             busy_o,
   output logic [CNT_W-1:0] ival_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   ctl_t             ctl_q;
   logic             pend_q;
   logic [1:0]       guard_q;
   logic [CNT_W-1:0] ival_q, cnt_q;
   logic             fast, src_tick, run, div_tick, cnt_tick;

   assign fast     = (ctl_q.src == SRC_FAST);
   assign src_tick = fast ? tick_hf_i : tick_lf_i;
   assign run      = ctl_q.en && (guard_q == 2'd0);

   tmr_divider #(.CODE_W(CODE_W)) i_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!run || fast),
      .tick_i (tick_lf_i),
      .code_i (ctl_q.div),
      .tick_o (div_tick)
   );

   assign cnt_tick = run && (fast ? tick_hf_i : div_tick);
   assign expire_o = cnt_tick && !pend_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         pend_q  <= 1'b0;
         guard_q <= 2'd0;
         ival_q  <= '0;
         cnt_q   <= '0;
      end else begin
         if (guard_q != 2'd0 && src_tick) guard_q <= guard_q - 2'd1;
         if (run && pend_q) begin
            cnt_q  <= ival_q;
            pend_q <= 1'b0;
         end else if (cnt_tick) begin
            if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
            else if (ctl_q.oneshot) begin
               ctl_q.en <= 1'b0;
               guard_q  <= GUARD_TICKS;
            end else                cnt_q <= ival_q;
         end
         if (ival_we_i && !ctl_q.en) ival_q <= ival_wd_i;
         if (ctl_we_i) begin
            ctl_q        <= ctl_wd_i;
            ctl_q.reload <= 1'b0;
            if (ctl_wd_i.reload)            pend_q  <= 1'b1;
            if (ctl_q.en && !ctl_wd_i.en)   guard_q <= GUARD_TICKS;
         end
      end
   end

   always_comb begin
      ctl_o        = ctl_q;
      ctl_o.reload = pend_q;
   end
   assign busy_o = (guard_q != 2'd0);
   assign ival_o = ival_q;
   assign cnt_o  = cnt_q;

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pend_q) |=> (cnt_q == $past(ival_q))); // R2
   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && !pend_q && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R3
   AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && ctl_q.oneshot && !ctl_we_i) |=> (!ctl_q.en && busy_o)); // R5
   AST_IVAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.en |=> $stable(ival_q)); // R8
   AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              mask_we_i,
   input  logic              stat_we_i,
   input  logic [NUM_CH-1:0] wd_i,
   output logic [NUM_CH-1:0] mask_o,
   output logic [NUM_CH-1:0] stat_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] mask_q, stat_q, clr;

   assign clr = stat_we_i ? wd_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (mask_we_i) mask_q <= wd_i;
         stat_q <= (stat_q & ~clr) | set_i;
      end
   end

   assign mask_o = mask_q;
   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & mask_q);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R11
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we_i && set_i == '0) |=> ((stat_q & $past(wd_i)) == '0)); // R6
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import tick_timer_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_hf_i,
   input  logic              tick_lf_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   localparam int LAST_ADDR = CH_BASE + CH_STRIDE * (NUM_CH - 1) + SUB_CNT;

   if (NUM_CH < 1 || LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("tick_timer_bank: NUM_CH does not fit the address space");
   end
   if (DATA_W != 32 || CODE_W != 3) begin : g_bad_width
      $error("tick_timer_bank: control layout needs DATA_W 32 and CODE_W 3");
   end

   logic [NUM_CH-1:0] expire, busy;
   logic [NUM_CH-1:0] mask, stat;
   ctl_t              ctl      [NUM_CH];
   logic [DATA_W-1:0] ival     [NUM_CH];
   logic [DATA_W-1:0] cnt      [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE * i);
      tmr_channel #(.CNT_W(DATA_W), .CODE_W(CODE_W)) i_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_hf_i (tick_hf_i),
         .tick_lf_i (tick_lf_i),
         .ctl_we_i  (bus_wr_i && bus_addr_i == BASE + ADDR_W'(SUB_CTL)),
         .ctl_wd_i  (ctl_t'(bus_wdata_i[CTL_W-1:0])),
         .ival_we_i (bus_wr_i && bus_addr_i == BASE + ADDR_W'(SUB_IVAL)),
         .ival_wd_i (bus_wdata_i),
         .ctl_o     (ctl[i]),
         .busy_o    (busy[i]),
         .ival_o    (ival[i]),
         .cnt_o     (cnt[i]),
         .expire_o  (expire[i])
      );
   end

   tmr_irq #(.NUM_CH(NUM_CH)) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (expire),
      .mask_we_i (bus_wr_i && bus_addr_i == ADDR_W'(OFS_MASK)),
      .stat_we_i (bus_wr_i && bus_addr_i == ADDR_W'(OFS_STAT)),
      .wd_i      (bus_wdata_i[NUM_CH-1:0]),
      .mask_o    (mask),
      .stat_o    (stat),
      .irq_o     (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(OFS_MASK)) bus_rdata_o[NUM_CH-1:0] = mask;
      if (bus_addr_i == ADDR_W'(OFS_STAT)) bus_rdata_o[NUM_CH-1:0] = stat;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CTL)) begin
            bus_rdata_o[CTL_W-1:0] = ctl[i];
            bus_rdata_o[BUSY_BIT]  = busy[i];
         end
         if (bus_addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_IVAL)) bus_rdata_o = ival[i];
         if (bus_addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CNT))  bus_rdata_o = cnt[i];
      end
   end

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq_o); // R7
endmodule

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hf = 1'b0, lf = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   tick_timer_bank i_tick_timer_bank (
      .clk(clk), .rst_n(rst_n), .tick_hf_i(hf), .tick_lf_i(lf),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic pulse_hf(input int n);
      repeat (n) begin
         @(negedge clk); hf = 1'b1;
         @(negedge clk); hf = 1'b0;
      end
   endtask

   task automatic pulse_lf(input int n);
      repeat (n) begin
         @(negedge clk); lf = 1'b1;
         @(negedge clk); lf = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      brd(8'h00, d); chk("R1 mask", d, 0);
      brd(8'h04, d); chk("R1 status", d, 0);
      brd(8'h10, d); chk("R1 ctl0", d, 0);
      brd(8'h14, d); chk("R1 ival0", d, 0);
      brd(8'h18, d); chk("R1 cnt0", d, 0);
      chk("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_load_count();
      logic [31:0] d;
      bwr(8'h14, 5);
      bwr(8'h10, 32'h07);
      idle(1);
      brd(8'h18, d); chk("R2 load", d, 5);
      brd(8'h10, d); chk("R2 ctl readback", d, 32'h05);
      pulse_lf(3);
      brd(8'h18, d); chk("R3 slow ignored", d, 5);
      pulse_hf(3);
      brd(8'h18, d); chk("R3 fast decrement", d, 2);
   endtask

   task automatic t_periodic_irq();
      logic [31:0] d;
      pulse_hf(2);
      brd(8'h18, d); chk("R4 at zero", d, 0);
      brd(8'h04, d); chk("R4 no early status", d, 0);
      pulse_hf(1);
      brd(8'h18, d); chk("R4 reload", d, 5);
      brd(8'h04, d); chk("R4 status", d, 1);
      chk("R7 masked", {31'd0, irq}, 0);
      bwr(8'h00, 2);
      chk("R7 other bit", {31'd0, irq}, 0);
      bwr(8'h00, 1);
      chk("R7 irq", {31'd0, irq}, 1);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      bwr(8'h04, 0);
      brd(8'h04, d); chk("R6 zero write", d, 1);
      bwr(8'h04, 1);
      brd(8'h04, d); chk("R6 clear", d, 0);
      chk("R6 irq low", {31'd0, irq}, 0);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      pulse_hf(5);
      brd(8'h18, d); chk("R11 at zero", d, 0);
      @(negedge clk); addr = 8'h04; wdata = 1; wr = 1'b1; hf = 1'b1;
      @(negedge clk); wr = 1'b0; hf = 1'b0;
      brd(8'h04, d); chk("R11 set wins", d, 1);
      bwr(8'h04, 1);
   endtask

   task automatic t_guard();
      logic [31:0] d;
      bwr(8'h24, 7);
      bwr(8'h20, 32'h07);
      idle(1);
      brd(8'h28, d); chk("R2 ch1 load", d, 7);
      bwr(8'h20, 32'h04);
      brd(8'h20, d); chk("R9 busy", d, 32'h8000_0004);
      bwr(8'h24, 9);
      brd(8'h24, d); chk("R8 accepted off", d, 9);
      bwr(8'h20, 32'h07);
      brd(8'h20, d); chk("R9 held", d, 32'h8000_0007);
      brd(8'h28, d); chk("R9 frozen", d, 7);
      pulse_hf(1);
      brd(8'h28, d); chk("R9 one tick", d, 7);
      pulse_hf(1);
      idle(1);
      brd(8'h28, d); chk("R9 late load", d, 9);
      brd(8'h20, d); chk("R9 released", d, 32'h05);
   endtask

   task automatic t_ival_lock();
      logic [31:0] d;
      bwr(8'h24, 3);
      brd(8'h24, d); chk("R8 ignored", d, 9);
   endtask

   task automatic t_divider();
      logic [31:0] d;
      bwr(8'h10, 32'h04);
      pulse_hf(2);
      bwr(8'h14, 20);
      bwr(8'h10, 32'h23);
      idle(1);
      brd(8'h18, d); chk("R10 load", d, 20);
      pulse_lf(3);
      brd(8'h18, d); chk("R10 three slow", d, 20);
      pulse_lf(1);
      brd(8'h18, d); chk("R10 fourth slow", d, 19);
      pulse_hf(1);
      brd(8'h18, d); chk("R10 fast ignored", d, 19);
      pulse_lf(4);
      brd(8'h18, d); chk("R10 next period", d, 18);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      bwr(8'h10, 32'h04);
      pulse_hf(2);
      bwr(8'h14, 1);
      bwr(8'h10, 32'h87);
      idle(1);
      brd(8'h18, d); chk("R5 load", d, 1);
      pulse_hf(1);
      brd(8'h04, d); chk("R5 not yet", d & 1, 0);
      pulse_hf(1);
      brd(8'h04, d); chk("R5 status", d & 1, 1);
      brd(8'h10, d); chk("R5 stopped", d, 32'h8000_0084);
      bwr(8'h04, 1);
      pulse_hf(1);
      brd(8'h18, d); chk("R5 stays zero", d, 0);
      brd(8'h04, d); chk("R5 no re-expiry", d & 1, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_load_count();
      t_periodic_irq();
      t_w1c();
      t_set_wins();
      t_guard();
      t_ival_lock();
      t_divider();
      t_oneshot();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule